// File: doc/BRIEF.md
# Outgoing Meta-Frame Composer with Bitstream Packing

This block produces the outgoing meta-frame byte stream. Its line and frame geometry match the incoming side: a fixed number of payload lines, each made of payload bytes and then a short line-blanking gap, and after them a few frame-blanking lines. Line and frame blanking are generated by the block's own counters and carry no data. Each payload position is classified as one of three kinds. The first bytes of every meta-frame form a reserved header window. Next comes a pass-on window, placed per meta-frame, that forwards uncompressed video from its source with one register of delay and no storage. The remaining free slots carry compressed bitstream bytes, taken from a show-ahead FIFO.

Two placement modes are available, and the mode is chosen per meta-frame. In tail-only mode, bitstream bytes go only into the free slots after the pass-on window. In spill mode, bitstream bytes also start in that tail. When the FIFO holds more bytes than the tail can take, the remainder is carried into the next meta-frame. There it fills the free slots between the header window and that frame's pass-on window. A free slot that gets no bitstream byte is sent as 0x00. A pass-on slot whose source byte is missing is also sent as 0x00, and an underrun pulse flags it.

Top module: `mfc_composer`

## Requirements
- R1: One meta-frame lasts (LINES+FRAME_BLANK) lines of (LINE_BYTES+LINE_BLANK) clocks. out_hblank_o is high for line columns at or above LINE_BYTES, and out_vblank_o is high for lines at or above LINES. out_valid_o is high exactly when neither flag is high. After reset the first clock is payload position 0.
- R2: out_sof_o is high for one clock, together with payload position 0 of each meta-frame.
- R3: Payload positions below HDR_BYTES are sent as 0x00 with out_valid_o high. They pop nothing and consume no pass-on byte.
- R4: Positions p with start <= p < start+len form the pass-on window. While pass_valid_i is high, pass_ready_o is high in the same clock, and pass_data_i appears on out_data_o one clock later.
- R5: In a pass-on slot with pass_valid_i low, pass_ready_o stays low. The byte is sent as 0x00 and underrun_o pulses with it.
- R6: In tail slots (p >= start+len), bs_pop_o is high when bs_level_i is nonzero, and the head byte bs_data_i is sent one clock later. With an empty FIFO the slot is sent as 0x00 and nothing is popped.
- R7: During blanking, out_data_o is 0x00, and bs_pop_o and pass_ready_o are low.
- R8: mode_i, pass_start_i and pass_len_i are sampled only at payload position 0. Changes later in the meta-frame have no effect on that meta-frame's placement.
- R9: In a meta-frame with no pending carry, the free slots between the header window and the pass-on window are sent as 0x00 and nothing is popped, even when the FIFO holds data.
- R10: In spill mode (mode_i=1), at the first tail slot bs_level_i is compared with the number of tail slots. If the level is larger, the next meta-frame's slots from HDR_BYTES up to its pass-on start pop bitstream bytes while the FIFO is non-empty, and pad after that.
- R11: A carry covers only the meta-frame that directly follows. In tail-only mode (mode_i=0) no carry is ever set.
- R12: All outputs except bs_pop_o and pass_ready_o are registered and lag the slot decision by one clock. bs_pop_o and pass_ready_o act in the slot's own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Placement mode: 0 tail-only, 1 spill into the next meta-frame |
| pass_start_i | input | POS_W | First payload position of the pass-on window |
| pass_len_i | input | POS_W | Length of the pass-on window in bytes |
| pass_data_i | input | 8 | Pass-on byte |
| pass_valid_i | input | 1 | Pass-on byte available |
| pass_ready_o | output | 1 | Pass-on byte consumed this clock |
| bs_data_i | input | 8 | Head byte of the bitstream FIFO (show-ahead) |
| bs_level_i | input | LVL_W | Number of bytes held in the bitstream FIFO |
| bs_pop_o | output | 1 | Pop the bitstream FIFO this clock |
| out_data_o | output | 8 | Outgoing meta-frame byte |
| out_valid_o | output | 1 | Byte is in the payload area |
| out_hblank_o | output | 1 | Line blanking |
| out_vblank_o | output | 1 | Frame blanking |
| out_sof_o | output | 1 | First payload byte of a meta-frame |
| underrun_o | output | 1 | Pass-on byte was missing and was padded |

## Verification
The stimulus runs a chain of meta-frames. One uses tail-only mode with a short FIFO, which separates tail filling from padding. One has a FIFO deeper than its tail in spill mode, and the frame after it shows the carry draining in the leading free slots and then padding. A spill-mode frame with a shallow FIFO shows that a carry does not persist into a second frame. A tail-only frame run while the FIFO still holds data shows that leading slots stay padded without a carry. A zero-length pass-on window puts the tail directly after the header. Some frames have gaps in the pass-on source, which exercise underrun padding, and some change their configuration inputs in mid-frame, which must leave placement unchanged.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    typedef enum logic [2:0] {
        SLOT_BLANK,
        SLOT_HDR,
        SLOT_PASS,
        SLOT_LEAD,
        SLOT_TAIL
    } slot_e;

    localparam logic [7:0] PAD_BYTE = 8'h00;
endpackage

// File: rtl/mfc_timing.sv
module mfc_timing #(
    parameter int LINE_BYTES  = 3200,
    parameter int LINE_BLANK  = 8,
    parameter int LINES       = 625,
    parameter int FRAME_BLANK = 5,
    parameter int POS_W       = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos_o,
    output logic             payload_o,
    output logic             hblank_o,
    output logic             vblank_o,
    output logic             first_o
);
    localparam int LINE_TOT  = LINE_BYTES + LINE_BLANK;
    localparam int FRAME_TOT = LINES + FRAME_BLANK;
    localparam int COL_W     = $clog2(LINE_TOT);
    localparam int LINE_W    = $clog2(FRAME_TOT);
    localparam int PAYLOAD   = LINE_BYTES * LINES;

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
        logic [POS_W-1:0]  pos;
    } tstate_t;

    tstate_t q, d;
    logic    line_end, frame_end;

    always_comb begin
        d         = q;
        hblank_o  = q.col >= COL_W'(LINE_BYTES);
        vblank_o  = q.line >= LINE_W'(LINES);
        payload_o = !hblank_o && !vblank_o;
        line_end  = q.col == COL_W'(LINE_TOT - 1);
        frame_end = line_end && (q.line == LINE_W'(FRAME_TOT - 1));
        if (line_end) begin
            d.col  = '0;
            d.line = frame_end ? '0 : q.line + LINE_W'(1);
        end else begin
            d.col = q.col + COL_W'(1);
        end
        if (frame_end)      d.pos = '0;
        else if (payload_o) d.pos = q.pos + POS_W'(1);
        pos_o   = q.pos;
        first_o = payload_o && (q.pos == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R1: a payload position never reaches the payload size
    p_pos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        payload_o |-> (int'(pos_o) < PAYLOAD));
    // R2: position 0 only at the top-left corner of the meta-frame
    p_first_corner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |-> (q.col == '0 && q.line == '0));
endmodule

// File: rtl/mfc_slot_class.sv
module mfc_slot_class
    import mfc_pkg::*;
#(
    parameter int POS_W     = 21,
    parameter int HDR_BYTES = 128
) (
    input  logic             payload_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] pass_start_i,
    input  logic [POS_W:0]   pass_end_i,
    output slot_e            slot_o
);
    logic [POS_W:0] pos_x;

    always_comb begin
        pos_x = {1'b0, pos_i};
        if (!payload_i)                             slot_o = SLOT_BLANK;
        else if (pos_x < (POS_W+1)'(HDR_BYTES))     slot_o = SLOT_HDR;
        else if (pos_x >= pass_end_i)               slot_o = SLOT_TAIL;
        else if (pos_x >= {1'b0, pass_start_i})     slot_o = SLOT_PASS;
        else                                        slot_o = SLOT_LEAD;
    end
endmodule

// File: rtl/mfc_composer.sv
module mfc_composer
    import mfc_pkg::*;
#(
    parameter int LINE_BYTES  = 3200,
    parameter int LINE_BLANK  = 8,
    parameter int LINES       = 625,
    parameter int FRAME_BLANK = 5,
    parameter int HDR_BYTES   = 128,
    parameter int LVL_W       = 12,
    localparam int PAYLOAD    = LINE_BYTES * LINES,
    localparam int POS_W      = $clog2(PAYLOAD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic [POS_W-1:0] pass_start_i,
    input  logic [POS_W-1:0] pass_len_i,
    input  logic [7:0]       pass_data_i,
    input  logic             pass_valid_i,
    output logic             pass_ready_o,
    input  logic [7:0]       bs_data_i,
    input  logic [LVL_W-1:0] bs_level_i,
    output logic             bs_pop_o,
    output logic [7:0]       out_data_o,
    output logic             out_valid_o,
    output logic             out_hblank_o,
    output logic             out_vblank_o,
    output logic             out_sof_o,
    output logic             underrun_o
);
    localparam int CMP_W = (LVL_W > POS_W + 1) ? LVL_W : POS_W + 1;

    typedef struct packed {
        logic             mode;
        logic [POS_W-1:0] pstart;
        logic [POS_W:0]   pend;
        logic             carry_pend;
        logic             carry_act;
        logic [7:0]       data;
        logic             valid;
        logic             hb;
        logic             vb;
        logic             sof;
        logic             und;
    } cstate_t;

    cstate_t q, d;

    logic [POS_W-1:0] pos;
    logic             payload, hblank, vblank, first;
    slot_e            slot;
    logic [CMP_W-1:0] lvl_x, tail_x;
    logic             tail_first, fifo_has;

    mfc_timing #(
        .LINE_BYTES (LINE_BYTES),
        .LINE_BLANK (LINE_BLANK),
        .LINES      (LINES),
        .FRAME_BLANK(FRAME_BLANK),
        .POS_W      (POS_W)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_o    (pos),
        .payload_o(payload),
        .hblank_o (hblank),
        .vblank_o (vblank),
        .first_o  (first)
    );

    mfc_slot_class #(
        .POS_W    (POS_W),
        .HDR_BYTES(HDR_BYTES)
    ) u_class (
        .payload_i   (payload),
        .pos_i       (pos),
        .pass_start_i(q.pstart),
        .pass_end_i  (q.pend),
        .slot_o      (slot)
    );

    always_comb begin
        d     = q;
        d.sof = first;
        d.und = 1'b0;
        d.hb  = hblank;
        d.vb  = vblank;
        d.valid = payload;

        fifo_has   = bs_level_i != '0;
        lvl_x      = CMP_W'(bs_level_i);
        tail_x     = CMP_W'((POS_W+1)'(PAYLOAD) - q.pend);
        tail_first = (slot == SLOT_TAIL) && ({1'b0, pos} == q.pend);

        // per-meta-frame configuration and carry hand-over
        if (first) begin
            d.mode       = mode_i;
            d.pstart     = pass_start_i;
            d.pend       = {1'b0, pass_start_i} + {1'b0, pass_len_i};
            d.carry_act  = q.carry_pend;
            d.carry_pend = 1'b0;
        end
        if (tail_first && q.mode && (lvl_x > tail_x))
            d.carry_pend = 1'b1;

        bs_pop_o     = fifo_has && ((slot == SLOT_TAIL) ||
                                    (slot == SLOT_LEAD && q.carry_act));
        pass_ready_o = (slot == SLOT_PASS) && pass_valid_i;

        if (bs_pop_o)          d.data = bs_data_i;
        else if (pass_ready_o) d.data = pass_data_i;
        else                   d.data = PAD_BYTE;

        if (slot == SLOT_PASS && !pass_valid_i) d.und = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_data_o   = q.data;
    assign out_valid_o  = q.valid;
    assign out_hblank_o = q.hb;
    assign out_vblank_o = q.vb;
    assign out_sof_o    = q.sof;
    assign underrun_o   = q.und;

    p_ready_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_ready_o |-> pass_valid_i);
    p_underrun_pads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> (out_valid_o && out_data_o == PAD_BYTE));
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bs_pop_o |-> (bs_level_i != '0));
    p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bs_pop_o |-> !pass_ready_o);
    p_blank_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hblank_o || out_vblank_o) |-> (!out_valid_o && out_data_o == PAD_BYTE));
    p_sof_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof_o |=> !out_sof_o);
    p_pop_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bs_pop_o |=> (out_data_o == $past(bs_data_i)));
endmodule

// File: tb/mfc_composer_test.sv
module mfc_composer_test;
    localparam int PERIOD = 10;
    localparam int LB     = 16;
    localparam int HB     = 2;
    localparam int LN     = 6;
    localparam int VB     = 1;
    localparam int HDR    = 8;
    localparam int LVL_W  = 8;
    localparam int PAY    = LB * LN;
    localparam int POS_W  = $clog2(PAY);
    localparam int FRAME_CLKS = (LB + HB) * (LN + VB);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_i = 1'b0;
    logic [POS_W-1:0] pass_start_i = '0;
    logic [POS_W-1:0] pass_len_i = '0;
    logic [7:0]       pass_data_i = '0;
    logic             pass_valid_i = 1'b0;
    logic             pass_ready_o;
    logic [7:0]       bs_data_i = '0;
    logic [LVL_W-1:0] bs_level_i = '0;
    logic             bs_pop_o;
    logic [7:0]       out_data_o;
    logic             out_valid_o, out_hblank_o, out_vblank_o, out_sof_o, underrun_o;

    mfc_composer #(
        .LINE_BYTES(LB), .LINE_BLANK(HB), .LINES(LN),
        .FRAME_BLANK(VB), .HDR_BYTES(HDR), .LVL_W(LVL_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .pass_start_i(pass_start_i), .pass_len_i(pass_len_i),
        .pass_data_i(pass_data_i), .pass_valid_i(pass_valid_i),
        .pass_ready_o(pass_ready_o), .bs_data_i(bs_data_i),
        .bs_level_i(bs_level_i), .bs_pop_o(bs_pop_o),
        .out_data_o(out_data_o), .out_valid_o(out_valid_o),
        .out_hblank_o(out_hblank_o), .out_vblank_o(out_vblank_o),
        .out_sof_o(out_sof_o), .underrun_o(underrun_o)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] bsq[$];
    int  bs_seq   = 8'h40;
    int  pass_ctr = 1;
    // reference model state
    int  col = 0, line = 0;
    int  m_mode = 0, m_ps = 0, m_pe = 0;
    bit  cpend = 0, cact = 0;
    // expected registered outputs
    int    e_data = 0;
    bit    e_valid = 0, e_hb = 0, e_vb = 0, e_sof = 0, e_und = 0;
    string e_tag = "R1";

    task automatic check_out();
        n_checks++;
        if (out_data_o !== e_data[7:0] || out_valid_o !== e_valid ||
            out_hblank_o !== e_hb || out_vblank_o !== e_vb ||
            out_sof_o !== e_sof || underrun_o !== e_und) begin
            n_fail++;
            $display("FAIL %s R12 outputs: actual data=%h v=%b hb=%b vb=%b sof=%b und=%b expected data=%h v=%b hb=%b vb=%b sof=%b und=%b",
                     e_tag, out_data_o, out_valid_o, out_hblank_o, out_vblank_o,
                     out_sof_o, underrun_o, e_data[7:0], e_valid, e_hb, e_vb, e_sof, e_und);
        end
    endtask

    task automatic slot(input bit gap);
        bit    pop = 0, rdy = 0;
        int    p;
        string tag;
        bs_level_i   = LVL_W'(bsq.size());
        bs_data_i    = (bsq.size() > 0) ? bsq[0] : 8'hEE;
        pass_valid_i = !gap;
        pass_data_i  = pass_ctr[7:0];
        #1;
        e_data = 0; e_valid = 0; e_sof = 0; e_und = 0;
        e_hb = (col >= LB);
        e_vb = (line >= LN);
        tag = e_hb || e_vb ? "R7" : "R1";
        if (!e_hb && !e_vb) begin
            p = line * LB + col;
            e_valid = 1;
            if (p == 0) begin
                // R8: configuration taken only here
                m_mode = mode_i; m_ps = pass_start_i; m_pe = pass_start_i + pass_len_i;
                cact = cpend; cpend = 0; e_sof = 1;
            end
            if (p < HDR) tag = (p == 0) ? "R2" : "R3";
            else if (p >= m_pe) begin
                tag = "R6";
                if (p == m_pe && m_mode == 1 && bsq.size() > PAY - m_pe) cpend = 1;
                if (bsq.size() > 0) begin pop = 1; e_data = bsq[0]; end
            end else if (p >= m_ps) begin
                tag = "R4";
                if (!gap) begin rdy = 1; e_data = pass_ctr[7:0]; end
                else begin tag = "R5"; e_und = 1; end
            end else begin
                tag = cact ? "R10" : "R9";
                if (cact && bsq.size() > 0) begin pop = 1; e_data = bsq[0]; end
            end
        end
        e_tag = tag;
        n_checks++;
        if (bs_pop_o !== pop || pass_ready_o !== rdy) begin
            n_fail++;
            $display("FAIL %s R11 handshake: actual pop=%b ready=%b expected pop=%b ready=%b (line %0d col %0d)",
                     tag, bs_pop_o, pass_ready_o, pop, rdy, line, col);
        end
        if (pop) void'(bsq.pop_front());
        if (rdy) pass_ctr++;
        if (col == LB + HB - 1) begin
            col = 0;
            line = (line == LN + VB - 1) ? 0 : line + 1;
        end else col++;
    endtask

    task automatic run_frame(input bit mode, input int ps, input int pl,
                             input int preload, input bit gaps, input bit garble);
        mode_i       = mode;
        pass_start_i = POS_W'(ps);
        pass_len_i   = POS_W'(pl);
        for (int i = 0; i < preload; i++) begin
            bsq.push_back(bs_seq[7:0]);
            bs_seq++;
        end
        for (int c = 0; c < FRAME_CLKS; c++) begin
            if (c > 0) begin
                @(negedge clk);
                check_out();
            end
            if (garble && c == 30) begin
                // R8: mid-frame changes must not move the windows
                mode_i = ~mode; pass_start_i = POS_W'(HDR + 1); pass_len_i = POS_W'(3);
            end
            slot(gaps && (c % 7 == 3));
        end
        @(negedge clk);
        check_out();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (out_data_o !== 8'h00 || out_valid_o !== 1'b0 || out_sof_o !== 1'b0 ||
            underrun_o !== 1'b0 || out_hblank_o !== 1'b0 || out_vblank_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual data=%h valid=%b sof=%b und=%b expected all zero",
                     out_data_o, out_valid_o, out_sof_o, underrun_o);
        end
        rst_n = 1'b1;
        run_frame(1'b0, 40, 32, 10, 1'b0, 1'b1); // tail-only, short FIFO, R8
        run_frame(1'b1, 40, 32, 40, 1'b1, 1'b0); // spill sets carry, R5 gaps
        run_frame(1'b1, 48, 40, 0,  1'b0, 1'b0); // R10 carry drains then pads
        run_frame(1'b1, 20, 10, 5,  1'b0, 1'b1); // R11 no stale carry
        run_frame(1'b0, 8,  0,  30, 1'b1, 1'b0); // empty pass window
        run_frame(1'b0, 40, 32, 60, 1'b0, 1'b0); // tail-only overfull, R11 no carry
        run_frame(1'b0, 40, 32, 0,  1'b0, 1'b0); // R9 leading slots pad with data queued
        run_frame(1'b1, 40, 32, 0,  1'b1, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule